// File: doc/BRIEF.md
# Host-Loaded Packet Staging Buffer

This block lets a host assemble a single packet through a 32-bit, word-addressed memory-mapped slave port. The block then hands that packet to a 512-bit streaming transmitter. The lower half of the 9-bit word address space maps onto 64 storage lines of 64 bytes each. A host write into that window fills a whole line with sixteen copies of the written word. The storage is therefore not byte-addressable. One control word carries two things: the packet length in bytes and a go flag.

The host sets the go flag to request transmission. The drain engine then checks the length. For a valid length it offers the stored lines, starting at line 0 and in ascending order, as beats on the stream. Each beat carries start, end and unused-byte markers. The go flag drops on its own once the final beat has been taken. While the flag is set, the buffer and the control word are locked against host writes. The host can poll the flag through the read path to learn when it may load the next packet.

Top module: `pkt_stage_buf`

## Requirements
- R1: Word address 0x100 is the control word. It reads as {length[15:0], fifteen zero bits, go}. The length is in bits [31:16] and the go flag is bit 0. Both reset to zero. Writes to word addresses 0x101 to 0x1FF change nothing.
- R2: A write to any word address whose bit 8 is zero stores sixteen copies of the 32-bit data into the line selected by address bits [5:0]. Address bits [7:6] alias onto the same line.
- R3: A read returns data with `mm_rvalid` high exactly one cycle later. A storage address returns bits [31:0] of its line. The control word returns its current value. Addresses 0x101 to 0x1FF return zero.
- R4: For a valid length L, the drain sends ceil(L/64) beats. Beat k carries line k in full, and beats run from k = 0 upward.
- R5: `tx_sop` is high only on the first beat and `tx_eop` only on the last. On the last beat, `tx_empty` equals 64*ceil(L/64) - L. On every other beat it is zero.
- R6: The go flag reads clear in the cycle after the last beat is accepted. `tx_valid` is never high while the go flag is clear.
- R7: While `tx_valid` is high and `tx_ready` is low, the beat's data and markers hold unchanged into the next cycle.
- R8: A length of 0 or above 4096 is rejected. The go flag clears in the cycle after it is first seen set, and no beat is sent.
- R9: While the go flag is set, host writes to storage and to the control word are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mm_write | input | 1 | Host write strobe |
| mm_read | input | 1 | Host read strobe |
| mm_addr | input | 9 | Host word address |
| mm_wdata | input | 32 | Host write data |
| mm_rdata | output | 32 | Host read data, valid with mm_rvalid |
| mm_rvalid | output | 1 | Read data valid, one cycle after mm_read |
| tx_valid | output | 1 | Stream beat valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 512 | Stream beat data |
| tx_sop | output | 1 | First beat of the packet |
| tx_eop | output | 1 | Last beat of the packet |
| tx_empty | output | 6 | Unused bytes in the last beat |

## Verification
Several properties are checked on every cycle. Beats hold steady under sink back-pressure. A packet opens with a start marker. Acceptance of the end beat clears the go flag. No beat appears while the flag is clear. A rejected length clears the flag at once. Read data arrives one cycle after the strobe. Other behaviour can only be shown by the bench's directed scenarios: the sixteen-fold line fill, address aliasing, line order and content, the unused-byte count for lengths on and off line boundaries, and writes being dropped while a packet is held.

// File: rtl/psb_pkg.sv
package psb_pkg;
  localparam int WORD_W     = 32;
  localparam int LINE_BYTES = 64;
  localparam int NUM_LINES  = 64;
  localparam int SIZE_W     = 16;
  localparam int ADDR_W     = 9;
  localparam int LINE_W     = LINE_BYTES * 8;
  localparam int IDX_W      = $clog2(NUM_LINES);
  localparam int PAD_W      = $clog2(LINE_BYTES);
  localparam int CAP_BYTES  = LINE_BYTES * NUM_LINES;
  localparam int COPIES     = LINE_W / WORD_W;
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(1) << (ADDR_W - 1);

  typedef enum logic {DR_IDLE, DR_SEND} drain_st_e;

  // Length accepted for transmission: non-zero and within capacity.
  function automatic logic size_ok(input logic [SIZE_W-1:0] sz);
    return (sz != '0) && (int'(sz) <= CAP_BYTES);
  endfunction

  // Index of the final line for a valid length.
  function automatic logic [IDX_W-1:0] last_line(input logic [SIZE_W-1:0] sz);
    logic [SIZE_W-1:0] m1;
    m1 = sz - SIZE_W'(1);
    return IDX_W'(m1 >> PAD_W);
  endfunction

  // Unused byte count in the final line.
  function automatic logic [PAD_W-1:0] pad_bytes(input logic [SIZE_W-1:0] sz);
    return PAD_W'(LINE_BYTES - int'(sz[PAD_W-1:0]));
  endfunction
endpackage

// File: rtl/psb_line_store.sv
module psb_line_store
  import psb_pkg::*;
(
  input  logic              clk,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_word,
  input  logic [IDX_W-1:0]  host_idx,
  output logic [WORD_W-1:0] host_word,
  input  logic [IDX_W-1:0]  drain_idx,
  output logic [LINE_W-1:0] drain_line
);
  logic [LINE_W-1:0] mem [NUM_LINES];
  logic [LINE_W-1:0] line_fill;

  for (genvar c = 0; c < COPIES; c++) begin : g_fill
    assign line_fill[c*WORD_W +: WORD_W] = wr_word;
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= line_fill;
  end

  assign host_word  = mem[host_idx][WORD_W-1:0];
  assign drain_line = mem[drain_idx];
endmodule

// File: rtl/psb_ctrl_reg.sv
module psb_ctrl_reg
  import psb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SIZE_W-1:0] wr_size,
  input  logic              wr_go,
  input  logic              clr,
  output logic [SIZE_W-1:0] size_q,
  output logic              go_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q <= '0;
      go_q   <= 1'b0;
    end else begin
      if (wr_en) begin
        size_q <= wr_size;
        go_q   <= wr_go;
      end
      if (clr) go_q <= 1'b0;
    end
  end

  AST_BAD_SIZE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (go_q && !size_ok(size_q)) |=> !go_q); // R8
endmodule

// File: rtl/psb_drain.sv
module psb_drain
  import psb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [SIZE_W-1:0] size,
  input  logic [LINE_W-1:0] line_data,
  output logic [IDX_W-1:0]  line_idx,
  output logic              clr,
  output logic              st_valid,
  input  logic              st_ready,
  output logic [LINE_W-1:0] st_data,
  output logic              st_sop,
  output logic              st_eop,
  output logic [PAD_W-1:0]  st_empty
);
  drain_st_e        state_q;
  logic [IDX_W-1:0] beat_q;
  logic [IDX_W-1:0] last_idx;
  logic             start_ev, reject_ev, accept_ev, final_ev;

  assign last_idx  = last_line(size);
  assign start_ev  = (state_q == DR_IDLE) && go && size_ok(size);
  assign reject_ev = (state_q == DR_IDLE) && go && !size_ok(size);
  assign st_valid  = (state_q == DR_SEND);
  assign accept_ev = st_valid && st_ready;
  assign final_ev  = accept_ev && (beat_q == last_idx);
  assign clr       = reject_ev || final_ev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= DR_IDLE;
      beat_q  <= '0;
    end else begin
      case (state_q)
        DR_IDLE: if (start_ev) begin
          state_q <= DR_SEND;
          beat_q  <= '0;
        end
        DR_SEND: if (final_ev) state_q <= DR_IDLE;
                 else if (accept_ev) beat_q <= beat_q + IDX_W'(1);
        default: state_q <= DR_IDLE;
      endcase
    end
  end

  assign line_idx = beat_q;
  assign st_data  = line_data;
  assign st_sop   = st_valid && (beat_q == '0);
  assign st_eop   = st_valid && (beat_q == last_idx);
  assign st_empty = st_eop ? pad_bytes(size) : '0;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_data) && $stable(st_sop)
                                 && $stable(st_eop) && $stable(st_empty))); // R7
  AST_OPEN_WITH_SOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_valid) |-> st_sop); // R5
endmodule

// File: rtl/pkt_stage_buf.sv
module pkt_stage_buf
  import psb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mm_write,
  input  logic              mm_read,
  input  logic [ADDR_W-1:0] mm_addr,
  input  logic [WORD_W-1:0] mm_wdata,
  output logic [WORD_W-1:0] mm_rdata,
  output logic              mm_rvalid,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [LINE_W-1:0] tx_data,
  output logic              tx_sop,
  output logic              tx_eop,
  output logic [PAD_W-1:0]  tx_empty
);
  logic              sel_store, sel_ctrl;
  logic              store_we, ctrl_we;
  logic [SIZE_W-1:0] size_q;
  logic              go_q;
  logic              drain_clr;
  logic [IDX_W-1:0]  drain_idx;
  logic [LINE_W-1:0] drain_line;
  logic [WORD_W-1:0] host_word;
  logic [WORD_W-1:0] rd_mux;

  assign sel_store = !mm_addr[ADDR_W-1];
  assign sel_ctrl  = (mm_addr == CTRL_ADDR);
  assign store_we  = mm_write && sel_store && !go_q;
  assign ctrl_we   = mm_write && sel_ctrl && !go_q;

  psb_line_store u_store (
    .clk        (clk),
    .wr_en      (store_we),
    .wr_idx     (mm_addr[IDX_W-1:0]),
    .wr_word    (mm_wdata),
    .host_idx   (mm_addr[IDX_W-1:0]),
    .host_word  (host_word),
    .drain_idx  (drain_idx),
    .drain_line (drain_line)
  );

  psb_ctrl_reg u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (ctrl_we),
    .wr_size (mm_wdata[WORD_W-1 -: SIZE_W]),
    .wr_go   (mm_wdata[0]),
    .clr     (drain_clr),
    .size_q  (size_q),
    .go_q    (go_q)
  );

  psb_drain u_drain (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (go_q),
    .size      (size_q),
    .line_data (drain_line),
    .line_idx  (drain_idx),
    .clr       (drain_clr),
    .st_valid  (tx_valid),
    .st_ready  (tx_ready),
    .st_data   (tx_data),
    .st_sop    (tx_sop),
    .st_eop    (tx_eop),
    .st_empty  (tx_empty)
  );

  always_comb begin
    rd_mux = '0;
    if (sel_store)     rd_mux = host_word;
    else if (sel_ctrl) rd_mux = {size_q, {(WORD_W-SIZE_W-1){1'b0}}, go_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mm_rdata  <= '0;
      mm_rvalid <= 1'b0;
    end else begin
      mm_rvalid <= mm_read;
      if (mm_read) mm_rdata <= rd_mux;
    end
  end

  AST_END_BEAT_CLEARS_GO: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_eop) |=> !go_q); // R6
  AST_QUIET_WITHOUT_GO: assert property (@(posedge clk) disable iff (!rst_n)
    !go_q |-> !tx_valid); // R6
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    mm_read |=> mm_rvalid); // R3
endmodule

// File: tb/sim_pkt_stage_buf.sv
module sim_pkt_stage_buf;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         mm_write, mm_read;
  logic [8:0]   mm_addr;
  logic [31:0]  mm_wdata, mm_rdata;
  logic         mm_rvalid;
  logic         tx_valid, tx_ready, tx_sop, tx_eop;
  logic [511:0] tx_data;
  logic [5:0]   tx_empty;

  int n_cmp = 0;
  int n_bad = 0;
  logic [31:0] mdl [64];

  always #5 clk = ~clk;

  pkt_stage_buf u0 (
    .clk(clk), .rst_n(rst_n), .mm_write(mm_write), .mm_read(mm_read),
    .mm_addr(mm_addr), .mm_wdata(mm_wdata), .mm_rdata(mm_rdata), .mm_rvalid(mm_rvalid),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_sop(tx_sop), .tx_eop(tx_eop), .tx_empty(tx_empty)
  );

  task automatic chk(input string tag, input logic [511:0] act, input logic [511:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic host_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    mm_write = 1'b1; mm_addr = a; mm_wdata = d;
    @(negedge clk);
    mm_write = 1'b0;
  endtask

  task automatic host_rd(input logic [8:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    mm_read = 1'b1; mm_addr = a;
    @(negedge clk);
    mm_read = 1'b0;
    chk({tag, " R3 rvalid"}, 512'(mm_rvalid), 512'(1'b1));
    chk(tag, 512'(mm_rdata), 512'(exp));
  endtask

  // Drains one packet of length sz; stall selects periodic back-pressure.
  task automatic collect(input int sz, input bit stall, input string tag);
    int n_exp, pad, beats, cyc;
    bit prev_stall;
    logic [520:0] snap;
    n_exp = (sz + 63) / 64;
    pad = n_exp * 64 - sz;
    beats = 0; cyc = 0; prev_stall = 0; snap = '0;
    while (beats < n_exp && cyc < 2000) begin
      @(negedge clk);
      cyc++;
      if (prev_stall)
        chk({tag, " R7 hold under stall"}, 512'({tx_valid, tx_data[7:0], tx_sop, tx_eop, tx_empty}),
            512'({1'b1, snap[7:0], snap[8], snap[9], snap[15:10]}));
      tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
      if (tx_valid && tx_ready) begin
        chk({tag, " R4 beat data"}, tx_data, {16{mdl[beats]}});
        chk({tag, " R5 sop"}, 512'(tx_sop), 512'(beats == 0));
        chk({tag, " R5 eop"}, 512'(tx_eop), 512'(beats == n_exp - 1));
        chk({tag, " R5 empty"}, 512'(tx_empty), 512'((beats == n_exp - 1) ? pad : 0));
        if (beats == n_exp - 1) begin
          mm_read = 1'b1; mm_addr = 9'h100;
        end
        beats++;
      end
      prev_stall = tx_valid && !tx_ready;
      snap = {505'(0), tx_empty, tx_eop, tx_sop, tx_data[7:0]};
    end
    chk({tag, " R4 beat count"}, 512'(beats), 512'(n_exp));
    @(negedge clk);
    mm_read = 1'b0;
    chk({tag, " R6 go still set at last accept"}, 512'(mm_rdata[0]), 512'(1'b1));
    chk({tag, " R6 no beat after end"}, 512'(tx_valid), 512'(1'b0));
    host_rd(9'h100, {sz[15:0], 16'h0}, {tag, " R6 go cleared"});
    tx_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 reset tx_valid", 512'(tx_valid), 512'(1'b0));
    chk("R1 reset rvalid", 512'(mm_rvalid), 512'(1'b0));
    host_rd(9'h100, 32'h0, "R1 reset control word");
  endtask

  task automatic t_fill;
    for (int i = 0; i < 64; i++) begin
      logic [31:0] v;
      v = 32'hA500_0000 ^ (i * 32'h0103_0507);
      host_wr(9'(i + ((i % 4) << 6)), v);
      mdl[i] = v;
    end
    host_rd(9'h005, mdl[5], "R2 plain read line 5");
    host_rd(9'h0C5, mdl[5], "R2 aliased read line 5");
    host_rd(9'h03F, mdl[63], "R2 read line 63");
  endtask

  task automatic t_ctrl_format;
    host_wr(9'h100, 32'hABCD_FFFE);
    host_rd(9'h100, 32'hABCD_0000, "R1 unused bits read zero");
    host_wr(9'h155, 32'hFFFF_FFFF);
    host_rd(9'h155, 32'h0, "R3 unmapped reads zero");
    host_rd(9'h100, 32'hABCD_0000, "R1 unmapped write no effect");
    chk("R1 no stream with go clear", 512'(tx_valid), 512'(1'b0));
  endtask

  task automatic t_send(input int sz, input bit stall, input string tag);
    host_wr(9'h100, {sz[15:0], 16'h0001});
    collect(sz, stall, tag);
  endtask

  task automatic t_invalid(input int sz, input string tag);
    host_wr(9'h100, {sz[15:0], 16'h0001});
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      tx_ready = 1'b1;
      chk({tag, " R8 nothing sent"}, 512'(tx_valid), 512'(1'b0));
    end
    host_rd(9'h100, {sz[15:0], 16'h0}, {tag, " R8 go cleared"});
    tx_ready = 1'b0;
  endtask

  task automatic t_locked;
    tx_ready = 1'b0;
    host_wr(9'h100, {16'd128, 16'h0001});
    host_wr(9'h000, 32'hDEAD_BEEF);
    host_wr(9'h100, {16'd64, 16'h0001});
    host_rd(9'h100, {16'd128, 16'h0001}, "R9 control write ignored");
    host_rd(9'h000, mdl[0], "R9 storage write ignored");
    collect(128, 1'b0, "R9 held packet");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mm_write = 1'b0; mm_read = 1'b0; mm_addr = '0; mm_wdata = '0; tx_ready = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_fill();
    t_ctrl_format();
    t_send(200, 1'b0, "len200");
    t_send(64, 1'b0, "len64");
    t_send(1, 1'b0, "len1");
    t_send(4096, 1'b1, "len4096 stalled");
    t_invalid(0, "len0");
    t_invalid(5000, "len5000");
    t_locked();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule